// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register file of one 16-pin general-purpose I/O port. A simple 32-bit bus reaches it through a word index, a write strobe, write data and combinational read data. It holds four stored registers:

- a mode field of two bits per pin,
- an output-type bit per pin,
- a pull field of two bits per pin,
- the output latch.

Their current contents drive the pin logic outside the block. Two write-only words change the output latch in one bus cycle with no read-modify-write: one sets and clears bits, the other only clears them. The input word is read-only and passes through the resolved pin levels that an external resolver supplies. Reset values are parameters, so every port instance on a chip can come up in its own configuration.

Mode code 1 is a general output. Codes 0, 2 and 3 all mean input. Pull code 0 is none, 1 is pull-up and 2 is pull-down. Output type 0 is push-pull and 1 is open-drain. The block stores these codes and does not interpret them itself. The block has no sequencing: each bus cycle is decoded and completed on its own.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is active and right after it, the mode register equals parameter MODE_RST and the pull register equals parameter PULL_RST. The output-type and output latch registers are 0.
- R2: A write to word 0 loads all 32 bits of the mode register (2 bits per pin, pin n at bits 2n+1:2n). The new value appears on mode_cfg and reads back at word 0 from the cycle after the write edge.
- R3: A write to word 3 loads all 32 bits of the pull register. A write to word 1 loads the output-type register from bits 15:0. Bits 31:16 of word 1 read as 0 and ignore writes.
- R4: A write to word 5 loads the output latch from bits 15:0. The latch keeps that value whatever the mode of the pins. Bits 31:16 read as 0 and ignore writes.
- R5: A write to word 6 sets latch bit n for each 1 in bit n (n = 0..15) and clears latch bit n for each 1 in bit n+16. When both bits are 1 for the same pin, the pin is set. Pins with both bits 0 keep their value.
- R6: A write to word 10 clears latch bit n for each 1 in bit n of bits 15:0. Zero bits and bits 31:16 leave the latch unchanged.
- R7: Words 6 and 10 always read as 0.
- R8: Word 4 reads the pin_level input zero-extended to 32 bits. Writes to word 4 change no register.
- R9: Words other than 0, 1, 3, 4, 5, 6 and 10 read as 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | 6 | Word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_level | input | 16 | Resolved pin levels from the external resolver |
| mode_cfg | output | 32 | Mode register contents |
| otype_cfg | output | 16 | Output-type register contents |
| pull_cfg | output | 32 | Pull register contents |
| out_latch | output | 16 | Output latch contents |

## Verification
The bench targets the following corner cases:

- **Set and clear on the same pin in word 6.** A design with the priority reversed leaves that pin low.
- **Clear word with upper bits set.** A design that honours bits 31:16 of word 10 clears pins it should leave alone.
- **Writes with the upper half set.** Writes to the output-type and output-latch words carry 1s in bits 31:16; a design that stores them shows nonzero upper read data.
- **Writes to read-only and unmapped words.** Writes to the input word and to unmapped indices 2, 7 and 63 must leave every register unchanged; a mis-decoded design corrupts a neighbour.
- **Read-back of the write-only words.** A design that returns the latch there would show it.

A behavioural model of the registers is compared against every output on every cycle, under long stretches of mixed traffic.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned WORD_MODE   = 0;
    localparam int unsigned WORD_OTYPE  = 1;
    localparam int unsigned WORD_PULL   = 3;
    localparam int unsigned WORD_IN     = 4;
    localparam int unsigned WORD_OUT    = 5;
    localparam int unsigned WORD_SETCLR = 6;
    localparam int unsigned WORD_CLR    = 10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_OTYPE,
        SEL_PULL,
        SEL_IN,
        SEL_OUT,
        SEL_SETCLR,
        SEL_CLR
    } reg_sel_e;

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        unique case (32'(addr))
            WORD_MODE:   sel = SEL_MODE;
            WORD_OTYPE:  sel = SEL_OTYPE;
            WORD_PULL:   sel = SEL_PULL;
            WORD_IN:     sel = SEL_IN;
            WORD_OUT:    sel = SEL_OUT;
            WORD_SETCLR: sel = SEL_SETCLR;
            WORD_CLR:    sel = SEL_CLR;
            default:     sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/gpio_bank_cfg_reg.sv
module gpio_bank_cfg_reg #(
    parameter int         W   = 32,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST;
        end else if (we) begin
            q <= d;
        end
    end

    // R9: a register not addressed by a write keeps its value
    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

    // R2: a write lands one edge later
    a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(d)));

endmodule

// File: rtl/gpio_bank_out_latch.sv
module gpio_bank_out_latch #(
    parameter int            PINS   = 16,
    parameter int            DATA_W = 32,
    parameter logic [PINS-1:0] RST  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_load,
    input  logic              wr_setclr,
    input  logic              wr_clr,
    input  logic [DATA_W-1:0] wdata,
    output logic [PINS-1:0]   q
);

    logic [PINS-1:0] set_bits;
    logic [PINS-1:0] clr_bits;
    logic [PINS-1:0] q_next;

    assign set_bits = wdata[PINS-1:0];
    assign clr_bits = wdata[2*PINS-1:PINS];

    always_comb begin
        q_next = q;
        if (wr_load) begin
            q_next = set_bits;
        end else if (wr_setclr) begin
            q_next = (q & ~clr_bits) | set_bits;
        end else if (wr_clr) begin
            q_next = q & ~set_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST;
        end else begin
            q <= q_next;
        end
    end

    // R5: every set bit ends high, even with its clear bit also written
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_setclr |=> ((q & $past(wdata[PINS-1:0])) == $past(wdata[PINS-1:0])));

    // R5: a clear without a set ends low
    a_r5_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_setclr |=> ((q & $past(wdata[2*PINS-1:PINS] & ~wdata[PINS-1:0])) == '0));

    // R6: clear-only word drops the named bits and keeps the rest
    a_r6_clr_only: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> (q == ($past(q) & ~$past(wdata[PINS-1:0]))));

    // R4: without a latch write the latch is stable
    a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_load || wr_setclr || wr_clr) |=> $stable(q));

endmodule

// File: rtl/gpio_bank_rd_mux.sv
module gpio_bank_rd_mux
    import gpio_bank_pkg::*;
#(
    parameter int PINS   = 16,
    parameter int DATA_W = 32
) (
    input  reg_sel_e            sel,
    input  logic [2*PINS-1:0]   mode,
    input  logic [PINS-1:0]     otype,
    input  logic [2*PINS-1:0]   pull,
    input  logic [PINS-1:0]     pin_level,
    input  logic [PINS-1:0]     latch,
    output logic [DATA_W-1:0]   rdata
);

    always_comb begin
        unique case (sel)
            SEL_MODE:   rdata = DATA_W'(mode);
            SEL_OTYPE:  rdata = DATA_W'(otype);
            SEL_PULL:   rdata = DATA_W'(pull);
            SEL_IN:     rdata = DATA_W'(pin_level);
            SEL_OUT:    rdata = DATA_W'(latch);
            SEL_SETCLR: rdata = '0;
            SEL_CLR:    rdata = '0;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_bank_pkg::*;
#(
    parameter int                PINS      = 16,
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 6,
    parameter logic [2*PINS-1:0] MODE_RST  = 32'hABFF_FFFF,
    parameter logic [2*PINS-1:0] PULL_RST  = 32'h6400_0000,
    parameter logic [PINS-1:0]   OTYPE_RST = '0,
    parameter logic [PINS-1:0]   OUT_RST   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pin_level,
    output logic [2*PINS-1:0] mode_cfg,
    output logic [PINS-1:0]   otype_cfg,
    output logic [2*PINS-1:0] pull_cfg,
    output logic [PINS-1:0]   out_latch
);

    localparam int FIELD_W = 2 * PINS;

    reg_sel_e sel;

    gpio_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_bank_cfg_reg #(.W(FIELD_W), .RST(MODE_RST)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_wr && sel == SEL_MODE),
        .d     (bus_wdata[FIELD_W-1:0]),
        .q     (mode_cfg)
    );

    gpio_bank_cfg_reg #(.W(PINS), .RST(OTYPE_RST)) u_otype (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_wr && sel == SEL_OTYPE),
        .d     (bus_wdata[PINS-1:0]),
        .q     (otype_cfg)
    );

    gpio_bank_cfg_reg #(.W(FIELD_W), .RST(PULL_RST)) u_pull (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_wr && sel == SEL_PULL),
        .d     (bus_wdata[FIELD_W-1:0]),
        .q     (pull_cfg)
    );

    gpio_bank_out_latch #(.PINS(PINS), .DATA_W(DATA_W), .RST(OUT_RST)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_load   (bus_wr && sel == SEL_OUT),
        .wr_setclr (bus_wr && sel == SEL_SETCLR),
        .wr_clr    (bus_wr && sel == SEL_CLR),
        .wdata     (bus_wdata),
        .q         (out_latch)
    );

    gpio_bank_rd_mux #(.PINS(PINS), .DATA_W(DATA_W)) u_rd (
        .sel       (sel),
        .mode      (mode_cfg),
        .otype     (otype_cfg),
        .pull      (pull_cfg),
        .pin_level (pin_level),
        .latch     (out_latch),
        .rdata     (bus_rdata)
    );

    // R7: write-only words return zero
    a_r7_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(bus_addr) == WORD_SETCLR || 32'(bus_addr) == WORD_CLR) |-> (bus_rdata == '0));

    // R8: input word mirrors the pin levels
    a_r8_in_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(bus_addr) == WORD_IN) |-> (bus_rdata == DATA_W'(pin_level)));

    // R4: latch word never returns upper bits
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(bus_addr) == WORD_OUT) |-> (bus_rdata[DATA_W-1:PINS] == '0));

    // R8: a write to the input word leaves every register unchanged
    a_r8_in_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && 32'(bus_addr) == WORD_IN) |=>
            ($stable(mode_cfg) && $stable(pull_cfg) && $stable(otype_cfg) && $stable(out_latch)));

endmodule

// File: tb/sim_gpio_port_regs.sv
module sim_gpio_port_regs;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [15:0] pin_level;
    logic [31:0] mode_cfg;
    logic [15:0] otype_cfg;
    logic [31:0] pull_cfg;
    logic [15:0] out_latch;

    always #5 clk = ~clk;

    gpio_port_regs u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_level (pin_level),
        .mode_cfg  (mode_cfg),
        .otype_cfg (otype_cfg),
        .pull_cfg  (pull_cfg),
        .out_latch (out_latch)
    );

    int    checks = 0;
    int    failures = 0;
    bit    chk_on = 0;
    bit    done = 0;
    string op_tag = "R4";

    // behavioural reference state
    logic [31:0] m_mode, m_pull;
    logic [15:0] m_otype, m_out;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode  = 32'hABFF_FFFF;
            m_pull  = 32'h6400_0000;
            m_otype = 16'h0;
            m_out   = 16'h0;
        end else if (bus_wr) begin
            case (int'(bus_addr))
                0:  m_mode = bus_wdata;
                1:  m_otype = bus_wdata[15:0];
                3:  m_pull = bus_wdata;
                5:  m_out = bus_wdata[15:0];
                6:  m_out = (m_out & ~bus_wdata[31:16]) | bus_wdata[15:0];
                10: m_out = m_out & ~bus_wdata[15:0];
                default: ;
            endcase
        end
    end

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        case (int'(a))
            0:  return m_mode;
            1:  return {16'h0, m_otype};
            3:  return m_pull;
            4:  return {16'h0, pin_level};
            5:  return {16'h0, m_out};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [5:0] a);
        case (int'(a))
            0:     return "R2";
            1, 3:  return "R3";
            4:     return "R8";
            5:     return "R4";
            6, 10: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            check("R2", "mode_cfg", mode_cfg, m_mode);
            check("R3", "pull_cfg", pull_cfg, m_pull);
            check("R3", "otype_cfg", {16'h0, otype_cfg}, {16'h0, m_otype});
            check(op_tag, "out_latch", {16'h0, out_latch}, {16'h0, m_out});
            check(read_tag(bus_addr), "bus_rdata", bus_rdata, exp_read(bus_addr));
        end
    end

    task automatic op(input bit w, input int a, input logic [31:0] d, input string t);
        @(negedge clk);
        #1;
        bus_wr    = w;
        bus_addr  = 6'(a);
        bus_wdata = d;
        op_tag    = t;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; pin_level = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        check("R1", "mode reset", mode_cfg, 32'hABFF_FFFF);
        check("R1", "pull reset", pull_cfg, 32'h6400_0000);
        check("R1", "otype reset", {16'h0, otype_cfg}, 32'h0);
        check("R1", "latch reset", {16'h0, out_latch}, 32'h0);
        #1;
        rst_n = 1;
        chk_on = 1;

        // R4: latch kept with pins in input mode, upper bits dropped
        op(1, 5, 32'hFFFF_1234, "R4");
        op(0, 5, 32'h0, "R4");
        // R2: mode write and read-back
        op(1, 0, 32'h5555_0000, "R4");
        op(0, 0, 32'h0, "R4");
        // R3: output type with upper bits, pull
        op(1, 1, 32'hFFFF_00F0, "R4");
        op(1, 3, 32'h1122_3344, "R4");
        op(0, 1, 32'h0, "R4");
        // R5: set wins over clear on bit 5, clear bit 4
        op(1, 6, 32'h0030_0020, "R5");
        op(1, 6, 32'h0002_0001, "R5");
        op(0, 6, 32'h0, "R7");
        // R6: clear-only, upper bits ignored
        op(1, 10, 32'hFFFF_0030, "R6");
        op(0, 10, 32'h0, "R7");
        // R8 and R9: writes ignored
        pin_level = 16'hA5C3;
        op(1, 4, 32'hFFFF_FFFF, "R8");
        op(1, 2, 32'hFFFF_FFFF, "R9");
        op(1, 7, 32'hFFFF_FFFF, "R9");
        op(1, 63, 32'hFFFF_FFFF, "R9");
        op(0, 4, 32'h0, "R8");
        op(0, 2, 32'h0, "R9");

        for (int i = 0; i < 3000; i++) begin
            int pick;
            int a;
            pick = int'($urandom_range(0, 10));
            case (pick)
                0: a = 0;  1: a = 1;  2: a = 3;  3: a = 4;
                4: a = 5;  5: a = 6;  6: a = 6;  7: a = 10;
                8: a = 2;  9: a = 63;
                default: a = int'($urandom_range(0, 63));
            endcase
            pin_level = 16'($urandom);
            op($urandom_range(0, 9) < 6, a, $urandom,
               (a == 6) ? "R5" : (a == 10) ? "R6" : "R4");
        end
        op(0, 0, 32'h0, "R4");
        @(negedge clk);
        #1;
        chk_on = 0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule